// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block converts a trailing-edge pulse-width request into the two gate enables of a synchronous step-down power stage: `gh_en` for the high-side switch and `gl_en` for the low-side switch. A divider on the fast system clock sets the switching period. The high-side request is raised when each switching cycle begins. It is withdrawn when the comparator input `pwm_trip` is sampled high. Between the two gates the block inserts a programmable dead time, and before turning one gate on it waits for the sensed state of the other gate to read low.

Two start-up and duty features surround this core. First, the high side can stay on through many full cycles at very high duty. When that happens, a counter forces the request off halfway through the cycle after the limit. The low side then conducts for the rest of that cycle, which refreshes the bootstrap supply. Second, after reset or after any idle period the low side stays blocked. It is released once the high side has been commanded on, or once the soft-start ramp reports that it has passed its upper level. The block holds both gates low whenever `idle` is asserted.

All pins are plain sampled levels. No data stream crosses the block's edge, so there is no handshake and no back-pressure. Rising edges of `clk` are numbered from 0, where edge 0 is the first rising edge after `rst_n` is released. A *cycle-start edge* is one whose number modulo `CYC_DIV` is 0. A *mid edge* is one whose number modulo `CYC_DIV` equals `CYC_DIV/2`.

Top module: `buck_gate_seq`

## Requirements
- R1: `cycle_tick` is 1 during reset. After reset it is 1 exactly in the clock period just before each cycle-start edge, so it is high for one clock in every `CYC_DIV`.
- R2: The high-side request is set at each cycle-start edge and cleared at any edge where `pwm_trip` is 1. If both occur at the same edge, `pwm_trip` wins. `gh_en` is 0 after the second rising edge following an edge that sampled `pwm_trip` high, so a `pwm_trip` held at 1 gives 0% duty.
- R3: Suppose the request has stayed set through `MAX_ON` complete cycles. It is then cleared at the mid edge of the next cycle, and `gh_en` falls one edge later. Under constant full demand, with sensed-gate lag no larger than `DEAD`, `gh_en` therefore falls after edge `MAX_ON*CYC_DIV + CYC_DIV/2 + 1` and then every `(MAX_ON+1)*CYC_DIV` edges. Each of these refresh pulses on `gl_en` lasts `CYC_DIV/2 - 1 - DEAD` clocks.
- R4: `gl_en` can rise only after one of two things has happened since the last reset or idle: `gh_en` was 1, or `ss_done` was sampled 1.
- R5: `gh_en` and `gl_en` are never 1 together. Both are 0 in reset.
- R6: After any edge that samples `idle` high, both gate enables are 0, and the high-side request is cleared until a later cycle-start edge.
- R7: A gate enable can rise only after the opposite enable has been 0 for at least `DEAD+1` clocks, and only when the opposite sensed input (`gh_fb` or `gl_fb`) is sampled 0 at that edge.
- R8: Any cycle whose request ends before its last edge resets the full-cycle count. After such a cycle, the next forced cut happens in the `(MAX_ON+1)`-th cycle counted from the following cycle start.
- R9: `idle` clears the start-up gating, so every restart blocks the low side again until R4 is satisfied once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_trip | input | 1 | Comparator result, 1 ends the high-side on time |
| ss_done | input | 1 | Soft-start ramp has passed its upper level |
| idle | input | 1 | Fault supervisor holds the stage off |
| gh_fb | input | 1 | Sensed high-side gate state, 1 = on |
| gl_fb | input | 1 | Sensed low-side gate state, 1 = on |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |
| cycle_tick | output | 1 | Switching-cycle start strobe |

## Verification
The bench builds the block with `CYC_DIV=16`, `DEAD=2` and the full `MAX_ON=20`. With these values a complete refresh period takes 336 clocks, and several periods fit in a short run, so the exact edge of the forced cut and the 5-clock refresh pulse can be checked. It sweeps the sensed-gate lag from 0 to 5 clocks. Lags longer than the dead time make the wait on the feedback inputs, rather than the counter, set the gap. Idle bursts and a held trip with the soft-start flag low drive the start-up gating through several re-arms.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  // One bit per switch of the half bridge.
  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;
endpackage

// File: rtl/bgs_cycle_timer.sv
module bgs_cycle_timer #(
  parameter int CYC_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic cyc_start,
  output logic mid_pt
);
  localparam int CW   = (CYC_DIV > 2) ? $clog2(CYC_DIV) : 1;
  localparam int HALF = CYC_DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(CYC_DIV - 1);
  localparam logic [CW-1:0] MIDV = CW'(HALF);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign cyc_start = (phase_q == '0);
  assign mid_pt    = (phase_q == MIDV);

  // The strobe lasts a single clock.
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);
  // The midpoint never coincides with the cycle start.
  assert_mid_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_start && mid_pt));
endmodule

// File: rtl/bgs_pwm_latch.sv
module bgs_pwm_latch #(
  parameter int MAX_ON = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic mid_pt,
  input  logic pwm_trip,
  input  logic idle,
  output logic hs_req
);
  localparam int OW = $clog2(MAX_ON + 1);
  localparam logic [OW-1:0] CAP = OW'(MAX_ON);

  logic [OW-1:0] full_cycles;
  logic          at_cap;

  assign at_cap = (full_cycles == CAP);

  // Trailing-edge request: set at cycle start, cut by the comparator or the cap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hs_req <= 1'b0;
    else if (idle)             hs_req <= 1'b0;
    else if (pwm_trip)         hs_req <= 1'b0;
    else if (cyc_start)        hs_req <= 1'b1;
    else if (mid_pt && at_cap) hs_req <= 1'b0;
  end

  // Counts cycles the request survived to their end; any short cycle clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full_cycles <= '0;
    else if (idle)   full_cycles <= '0;
    else if (cyc_start) begin
      if (!hs_req)      full_cycles <= '0;
      else if (!at_cap) full_cycles <= full_cycles + 1'b1;
    end
  end

  assert_trip_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_trip |=> !hs_req);
  // A fall not caused by the comparator or idle lands only on the midpoint.
  assert_forced_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_req) && !$past(pwm_trip) && !$past(idle)) |-> $past(mid_pt));
  assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !hs_req) |=> (full_cycles == '0));
  assert_idle_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !hs_req);
endmodule

// File: rtl/bgs_start_gate.sv
module bgs_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic hs_tried,
  input  logic ss_done,
  output logic lo_allowed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lo_allowed <= 1'b0;
    else if (idle)                lo_allowed <= 1'b0;
    else if (hs_tried || ss_done) lo_allowed <= 1'b1;
  end

  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !lo_allowed);
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_allowed) |-> ($past(hs_tried) || $past(ss_done)));
endmodule

// File: rtl/bgs_dead_time.sv
module bgs_dead_time
  import bgs_pkg::*;
#(
  parameter int DEAD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gate_pair_t want,
  input  gate_pair_t fb,
  output gate_pair_t en
);
  localparam int DW = $clog2(DEAD + 1);
  localparam logic [DW-1:0] GAP = DW'(DEAD);

  logic [DW-1:0] quiet_cnt;
  logic          quiet_ok;

  assign quiet_ok = (quiet_cnt == GAP);

  // Counts clocks with both gates off; restarts whenever either is on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_cnt <= '0;
    else if (en.hi || en.lo)   quiet_cnt <= '0;
    else if (!quiet_ok)        quiet_cnt <= quiet_cnt + 1'b1;
  end

  // Turn-off is immediate; turn-on waits for the gap and the sensed opposite gate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
    end else begin
      en.hi <= want.hi && (en.hi || (quiet_ok && !en.lo && !fb.lo));
      en.lo <= want.lo && (en.lo || (quiet_ok && !en.hi && !fb.hi));
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en.hi && en.lo));
  assert_gap_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en.lo) |-> (!$past(en.hi) && !$past(fb.hi)));
  assert_gap_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en.hi) |-> (!$past(en.lo) && !$past(fb.lo)));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import bgs_pkg::*;
#(
  parameter int CYC_DIV = 64,
  parameter int DEAD    = 4,
  parameter int MAX_ON  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_trip,
  input  logic ss_done,
  input  logic idle,
  input  logic gh_fb,
  input  logic gl_fb,
  output logic gh_en,
  output logic gl_en,
  output logic cycle_tick
);
  logic       cyc_start;
  logic       mid_pt;
  logic       hs_req;
  logic       lo_allowed;
  gate_pair_t want;
  gate_pair_t sensed;
  gate_pair_t drive;

  bgs_cycle_timer #(.CYC_DIV(CYC_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .mid_pt    (mid_pt)
  );

  bgs_pwm_latch #(.MAX_ON(MAX_ON)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .mid_pt    (mid_pt),
    .pwm_trip  (pwm_trip),
    .idle      (idle),
    .hs_req    (hs_req)
  );

  bgs_start_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (idle),
    .hs_tried   (drive.hi),
    .ss_done    (ss_done),
    .lo_allowed (lo_allowed)
  );

  always_comb begin
    want.hi = hs_req && !idle;
    want.lo = !hs_req && lo_allowed && !idle;
    sensed.hi = gh_fb;
    sensed.lo = gl_fb;
  end

  bgs_dead_time #(.DEAD(DEAD)) u_dead (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (want),
    .fb    (sensed),
    .en    (drive)
  );

  assign gh_en      = drive.hi;
  assign gl_en      = drive.lo;
  assign cycle_tick = cyc_start;

  assert_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!gh_en && !gl_en));
  assert_lo_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_en) |-> $past(lo_allowed));
  assert_want_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(want.hi && want.lo));
endmodule

// File: tb/tb_buck_gate_seq.sv
`timescale 1ns/1ps
module tb_buck_gate_seq;
  localparam int N  = 16;
  localparam int DT = 2;
  localparam int MX = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_trip = 1'b0, ss_done = 1'b0, idle = 1'b0;
  logic gh_fb = 1'b0, gl_fb = 1'b0;
  logic gh_en, gl_en, cycle_tick;

  buck_gate_seq #(.CYC_DIV(N), .DEAD(DT), .MAX_ON(MX)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_trip(pwm_trip), .ss_done(ss_done),
    .idle(idle), .gh_fb(gh_fb), .gl_fb(gl_fb),
    .gh_en(gh_en), .gl_en(gl_en), .cycle_tick(cycle_tick)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int m = 0, lag = 1;
  logic [15:0] gh_hist = '0, gl_hist = '0;
  logic prev_gh = 1'b0, prev_gl = 1'b0, t1 = 1'b0, t2 = 1'b0;
  int gh_low_run = 1000, gl_low_run = 1000;
  bit started_flag = 1'b0;
  int falls[16];
  int nf = 0;
  int glruns[16];
  int ngl = 0, glrun = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, m);
    end
  endtask

  function automatic int refresh_fall(int j);
    return MX*N + N/2 + 2 + j*(MX+1)*N;
  endfunction

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      m++;
      t2 = t1;
      t1 = pwm_trip;
      chk(!(gh_en && gl_en), "R5", "both gates on", 1, 0);
      if (idle) chk(!gh_en && !gl_en, "R6", "gate on after idle", int'(gh_en)+int'(gl_en), 0);
      chk(cycle_tick == (m % N == 0), "R1", "cycle_tick", int'(cycle_tick), int'(m % N == 0));
      if (t2) chk(!gh_en, "R2", "gh_en after trip", int'(gh_en), 0);
      if (gl_en && !prev_gl) begin
        chk(gh_low_run >= DT+1 && !gh_fb, "R7", "gl rise gap", gh_low_run, DT+1);
        chk(started_flag, "R4", "gl rise before release", 0, 1);
      end
      if (gh_en && !prev_gh)
        chk(gl_low_run >= DT+1 && !gl_fb, "R7", "gh rise gap", gl_low_run, DT+1);
      if (prev_gh && !gh_en) begin
        if (nf < 16) falls[nf] = m;
        nf++;
      end
      if (gl_en) glrun++;
      else if (prev_gl) begin
        if (ngl < 16) glruns[ngl] = glrun;
        ngl++;
        glrun = 0;
      end
      if (idle) started_flag = 1'b0;
      else if (gh_en || ss_done) started_flag = 1'b1;
    end
    gh_low_run = gh_en ? 0 : gh_low_run + 1;
    gl_low_run = gl_en ? 0 : gl_low_run + 1;
    gh_hist = {gh_hist[14:0], gh_en};
    gl_hist = {gl_hist[14:0], gl_en};
    gh_fb = gh_hist[lag];
    gl_fb = gl_hist[lag];
    prev_gh = gh_en;
    prev_gl = gl_en;
  endtask

  task automatic do_reset(bit trip_v, bit ss_v);
    rst_n = 1'b0;
    pwm_trip = trip_v; ss_done = ss_v; idle = 1'b0;
    repeat (3) @(negedge clk);
    chk(!gh_en && !gl_en, "R5", "gates in reset", int'(gh_en)+int'(gl_en), 0);
    chk(cycle_tick == 1'b1, "R1", "tick in reset", int'(cycle_tick), 1);
    m = 0; t1 = 1'b0; t2 = 1'b0;
    gh_hist = '0; gl_hist = '0; gh_fb = 1'b0; gl_fb = 1'b0;
    prev_gh = 1'b0; prev_gl = 1'b0;
    gh_low_run = 1000; gl_low_run = 1000;
    started_flag = 1'b0; nf = 0; ngl = 0; glrun = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seen;
    void'($urandom(32'd9071));

    // R3: steady full demand, timeout refresh pulses.
    lag = 1;
    do_reset(1'b0, 1'b1);
    while (m < refresh_fall(2) + 20) step();
    for (int j = 0; j < 3; j++)
      chk(nf > j && falls[j] == refresh_fall(j), "R3", "forced gh fall edge",
          (nf > j) ? falls[j] : -1, refresh_fall(j));
    for (int j = 0; j < 3; j++)
      chk(ngl > j && glruns[j] == N/2 - 1 - DT, "R3", "refresh pulse width",
          (ngl > j) ? glruns[j] : -1, N/2 - 1 - DT);

    // R8 and R2: one tripped cycle restarts the full-cycle count.
    do_reset(1'b0, 1'b1);
    while (m < 31*N + 20) begin
      pwm_trip = (m == 10*N + 4);
      step();
    end
    pwm_trip = 1'b0;
    chk(nf > 0 && falls[0] == 10*N + 6, "R2", "gh fall after trip",
        (nf > 0) ? falls[0] : -1, 10*N + 6);
    chk(nf > 1 && falls[1] == 31*N + 10, "R8", "cut after count reset",
        (nf > 1) ? falls[1] : -1, 31*N + 10);

    // R4, R9, R2: held trip, gating release and re-arm.
    do_reset(1'b1, 1'b0);
    seen = 0;
    repeat (5*N) begin step(); seen += int'(gl_en) + int'(gh_en); end
    chk(seen == 0, "R4", "no gate while gated and 0% duty", seen, 0);
    ss_done = 1'b1;
    repeat (DT + 4) step();
    chk(gl_en == 1'b1, "R4", "gl released by soft-start flag", int'(gl_en), 1);
    ss_done = 1'b0; idle = 1'b1;
    repeat (3) step();
    chk(!gl_en && !gh_en, "R6", "idle holds gates", int'(gl_en)+int'(gh_en), 0);
    idle = 1'b0;
    seen = 0;
    repeat (5*N) begin step(); seen += int'(gl_en); end
    chk(seen == 0, "R9", "gl blocked after idle", seen, 0);
    seen = 0;
    repeat (4*N) begin
      pwm_trip = ((m % N) == 6);
      step();
      seen += int'(gl_en);
    end
    chk(seen > 0, "R4", "gl released by high-side attempt", seen, 1);

    // Random phases, lags and idle bursts under per-edge rule checks.
    do_reset(1'b0, 1'b0);
    begin
      int tp = 5, idle_left = 0;
      for (int k = 0; k < 3000; k++) begin
        if ((m % N) == 0) begin
          tp = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, N-1));
          if ($urandom_range(0, 7) == 0) lag = int'($urandom_range(0, 5));
          if ($urandom_range(0, 5) == 0) ss_done = ~ss_done;
        end
        if (idle_left > 0) idle_left--;
        else if ($urandom_range(0, 199) == 0) idle_left = int'($urandom_range(2, 5));
        idle = (idle_left > 0);
        pwm_trip = (tp != 0) && ((m % N) == tp);
        step();
      end
    end
    idle = 1'b0; pwm_trip = 1'b0;
    repeat (4) step();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule